// File: doc/BRIEF.md
# Double-Data-Rate Output Serializer

This block turns two single-rate bit streams into one double-rate bit for a differential output driver. On every rising edge of the DDR clock the user logic hands over a pair of bits. One bit is driven while the clock is high and the other while the clock is low. The final two-way selection is steered by the DDR clock itself. The block keeps that output free of glitches in one of two ways, chosen by a parameter.

With `MODE = 0` (pipelined select), each half-bit is moved into a holding register half a cycle before the clock selects it. The selector inputs are therefore never changing at the moment the select switches. With `MODE = 1` (retimed output), the selector works directly on the captured pair. Its output is then re-registered by a second clock that runs at exactly twice the DDR rate, with a small phase delay. Any race at the selector settles before that register samples it.

An active-low asynchronous reset clears every register, so an idle serializer drives a low level.

Top module: `ddr_ser_top`

## Requirements
- R1: While `rst_ni` is low, `q_o` is 0 in both modes, including immediately after reset is asserted mid-cycle. In mode 0, the first full DDR cycle after reset is released also drives 0 in both halves.
- R2: The pair `dr_i`/`df_i` is sampled only on the rising edge of `clk_i`. Values that the inputs take between rising edges have no effect on `q_o`.
- R3: In mode 0, while `clk_i` is high during the cycle that follows the capturing rising edge, `q_o` equals the captured `dr_i`.
- R4: In mode 0, while `clk_i` is low during that same following cycle, `q_o` equals the captured `df_i`.
- R5: In mode 1, the captured `dr_i` appears at `q_o` from the first `clk2x_i` rising edge after the capturing `clk_i` rising edge. The captured `df_i` appears from the first `clk2x_i` rising edge after the next `clk_i` falling edge. The delay of `clk2x_i` behind `clk_i` must be shorter than half a DDR period.
- R6: Within one half-cycle window, `q_o` changes at most once. It does not change at all when the new half-bit equals the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | DDR clock; also the half-bit select (high selects the rising-half bit) |
| clk2x_i | input | 1 | Double-rate, phase-delayed clock for the output register (unused in mode 0) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dr_i | input | 1 | Bit to be sent while `clk_i` is high |
| df_i | input | 1 | Bit to be sent while `clk_i` is low |
| q_o | output | 1 | Serialized double-rate output bit |

## Verification
A holding register that captures on the wrong edge, or a selector that reads an unstable input, shows up within a single half-cycle. The symptom is an extra toggle of `q_o` inside that half, or the bit of the neighbouring half or of the previous pair. A broken latency stage shifts the whole output stream by one half or one full DDR cycle. This is visible on the second pair after any data change. A reset that misses a register leaves a stale 1 on `q_o` during the first cycle after release. Inputs that are sampled away from the rising edge show up as a wiggle on the inputs reaching the output.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;

   // variant selector values for the MODE parameter
   localparam int unsigned MODE_PIPE   = 0;
   localparam int unsigned MODE_RETIME = 1;

   // level every register takes while reset is asserted
   localparam logic IDLE_LEVEL = 1'b0;

   // one DDR cycle worth of data: hi is sent while the clock is high
   typedef struct packed {
      logic hi;
      logic lo;
   } half_pair_t;

   localparam half_pair_t IDLE_PAIR = '{hi: IDLE_LEVEL, lo: IDLE_LEVEL};

endpackage

// File: rtl/ddr_ser_capture.sv
module ddr_ser_capture
   import ddr_ser_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  half_pair_t pair_i,
   output half_pair_t pair_o
);

   half_pair_t pair_q;

   // user pair is taken only on the rising DDR edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pair_q <= IDLE_PAIR;
      end else begin
         pair_q <= pair_i;
      end
   end

   assign pair_o = pair_q;

endmodule

// File: rtl/ddr_ser_selmux.sv
module ddr_ser_selmux
   import ddr_ser_pkg::*;
(
   input  logic       sel_i,
   input  half_pair_t pair_i,
   output logic       y_o
);

   // select high passes the high-half bit, select low the low-half bit
   always_comb begin
      y_o = sel_i ? pair_i.hi : pair_i.lo;
   end

endmodule

// File: rtl/ddr_ser_pipe.sv
module ddr_ser_pipe
   import ddr_ser_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  half_pair_t pair_i,
   output half_pair_t stage_o
);

   logic hi_q;
   logic lo_q;

   // high-half bit moves on the falling edge: settled before the next rise selects it
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q <= IDLE_LEVEL;
      end else begin
         hi_q <= pair_i.hi;
      end
   end

   // low-half bit moves on the rising edge: settled half a cycle before the low phase
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_q <= IDLE_LEVEL;
      end else begin
         lo_q <= pair_i.lo;
      end
   end

   assign stage_o = '{hi: hi_q, lo: lo_q};

   // R3
   hi_ready_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_o.hi == pair_i.hi);

endmodule

// File: rtl/ddr_ser_retime.sv
module ddr_ser_retime
   import ddr_ser_pkg::*;
(
   input  logic clk2x_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic q_q;

   // delayed double-rate clock samples the selector after it has settled
   always_ff @(posedge clk2x_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_q <= IDLE_LEVEL;
      end else begin
         q_q <= d_i;
      end
   end

   assign q_o = q_q;

endmodule

// File: rtl/ddr_ser_top.sv
module ddr_ser_top
   import ddr_ser_pkg::*;
#(
   parameter int unsigned MODE = MODE_PIPE
) (
   input  logic clk_i,
   input  logic clk2x_i,
   input  logic rst_ni,
   input  logic dr_i,
   input  logic df_i,
   output logic q_o
);

   localparam bit USE_PIPE = (MODE == MODE_PIPE);

   half_pair_t pair_in;
   half_pair_t pair_cap;

   assign pair_in = '{hi: dr_i, lo: df_i};

   ddr_ser_capture u_capture (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pair_i (pair_in),
      .pair_o (pair_cap)
   );

   if (MODE != MODE_PIPE && MODE != MODE_RETIME) begin : g_bad_mode
      $error("ddr_ser_top: MODE must be 0 (pipelined) or 1 (retimed)");
   end

   if (USE_PIPE) begin : g_pipe
      half_pair_t stage;
      logic       unused_clk2x;
      logic       rise_seen_q;
      logic       fall_seen_q;

      assign unused_clk2x = clk2x_i;

      ddr_ser_pipe u_pipe (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .pair_i  (pair_cap),
         .stage_o (stage)
      );

      ddr_ser_selmux u_mux (
         .sel_i  (clk_i),
         .pair_i (stage),
         .y_o    (q_o)
      );

      // checker-only: an edge of each kind has passed since reset
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rise_seen_q <= 1'b0;
         else         rise_seen_q <= 1'b1;
      end
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni) fall_seen_q <= 1'b0;
         else         fall_seen_q <= 1'b1;
      end

      // R3
      pipe_hi_out_chk : assert property (@(negedge clk_i) disable iff (!rst_ni)
         fall_seen_q |-> (q_o == $past(pair_cap.hi)));

      // R4
      pipe_lo_out_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
         rise_seen_q |-> (q_o == $past(pair_cap.lo)));
   end else begin : g_retime
      logic mux_y;

      ddr_ser_selmux u_mux (
         .sel_i  (clk_i),
         .pair_i (pair_cap),
         .y_o    (mux_y)
      );

      ddr_ser_retime u_retime (
         .clk2x_i (clk2x_i),
         .rst_ni  (rst_ni),
         .d_i     (mux_y),
         .q_o     (q_o)
      );

      // R5
      retime_hi_out_chk : assert property (@(negedge clk_i) disable iff (!rst_ni)
         q_o == pair_cap.hi);

      // R5
      retime_lo_out_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
         q_o == pair_cap.lo);
   end

   // R1
   idle_low_chk : assert property (@(posedge clk_i)
      !rst_ni |-> (q_o == IDLE_LEVEL));

endmodule

// File: tb/ddr_ser_top_bench.sv
module ddr_ser_top_bench;

   localparam int CLK_PERIOD = 40;
   localparam int HALF       = CLK_PERIOD / 2;
   localparam int X2_DELAY   = 5;
   localparam int NVEC       = 16;
   // bit 1 = high-half bit, bit 0 = low-half bit
   localparam logic [1:0] VEC [NVEC] = '{
      2'b10, 2'b10, 2'b01, 2'b11, 2'b11, 2'b00, 2'b00, 2'b10,
      2'b01, 2'b01, 2'b11, 2'b00, 2'b10, 2'b11, 2'b01, 2'b00
   };

   logic clk   = 1'b0;
   logic clk2x = 1'b0;
   logic rst_n = 1'b1;
   logic dr    = 1'b0;
   logic df    = 1'b0;
   logic q0;
   logic q1;

   int total = 0;
   int bad   = 0;
   int tog0  = 0;
   int tog1  = 0;
   logic last0 = 1'b0;
   logic last1 = 1'b0;
   bit gl_on = 1'b0;

   ddr_ser_top #(.MODE(0)) u_ddr_ser_top (
      .clk_i (clk), .clk2x_i (clk2x), .rst_ni (rst_n),
      .dr_i (dr), .df_i (df), .q_o (q0)
   );

   ddr_ser_top #(.MODE(1)) u_ddr_ser_top_reg (
      .clk_i (clk), .clk2x_i (clk2x), .rst_ni (rst_n),
      .dr_i (dr), .df_i (df), .q_o (q1)
   );

   initial forever #(HALF) clk = ~clk;

   initial begin
      #(HALF + X2_DELAY);
      forever begin
         clk2x = 1'b1;
         #(HALF / 2);
         clk2x = 1'b0;
         #(HALF / 2);
      end
   end

   always @(q0) tog0++;
   always @(q1) tog1++;

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_n(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // R6: transitions in the half-cycle window since the previous sample
   task automatic glitch_window();
      if (gl_on) begin
         chk_n("R6 mode0 toggles", tog0, (q0 !== last0) ? 1 : 0);
         chk_n("R6 mode1 toggles", tog1, (q1 !== last1) ? 1 : 0);
      end
      last0 = q0;
      last1 = q1;
      tog0  = 0;
      tog1  = 0;
      gl_on = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 2000);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [1:0] p1;
      logic [1:0] p2;
      p1 = 2'b00;
      p2 = 2'b00;
      #1 rst_n = 1'b0;

      // R1 reset state in both clock phases
      @(posedge clk);
      #5;
      chk("R1 reset hi mode0", q0, 1'b0);
      chk("R1 reset hi mode1", q1, 1'b0);
      #(HALF);
      chk("R1 reset lo mode0", q0, 1'b0);
      chk("R1 reset lo mode1", q1, 1'b0);
      @(posedge clk);
      #10 rst_n = 1'b1;

      // table walk: R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         @(posedge clk);
         #7;
         dr = VEC[i][1];
         df = VEC[i][0];
         #8;
         chk("R3 mode0 high half", q0, p2[1]);
         chk("R5 mode1 high half", q1, p1[1]);
         glitch_window();
         #(HALF);
         chk("R4 mode0 low half", q0, p2[0]);
         chk("R5 mode1 low half", q1, p1[0]);
         glitch_window();
         p2 = p1;
         p1 = VEC[i];
      end
      gl_on = 1'b0;

      // R2: input wiggles between rising edges are ignored
      @(posedge clk);
      #5 begin dr = 1'b0; df = 1'b1; end
      #20 begin dr = 1'b1; df = 1'b1; end
      #10 begin dr = 1'b1; df = 1'b0; end
      @(posedge clk);
      #7 begin dr = 1'b0; df = 1'b1; end
      #8;
      chk("R2 mode1 high half", q1, 1'b1);
      #(HALF);
      chk("R2 mode1 low half", q1, 1'b0);
      @(posedge clk);
      #15;
      chk("R2 mode0 high half", q0, 1'b1);
      #(HALF);
      chk("R2 mode0 low half", q0, 1'b0);

      // R1: asynchronous reset in mid cycle, then clean restart
      @(posedge clk);
      #7 begin dr = 1'b1; df = 1'b1; end
      @(posedge clk);
      @(posedge clk);
      #10 rst_n = 1'b0;
      #2;
      chk("R1 async mode0", q0, 1'b0);
      chk("R1 async mode1", q1, 1'b0);
      #10;
      chk("R1 held mode0", q0, 1'b0);
      chk("R1 held mode1", q1, 1'b0);
      #8 rst_n = 1'b1;
      @(posedge clk);
      #15;
      chk("R1 first cycle hi mode0", q0, 1'b0);
      chk("R5 restart hi mode1", q1, 1'b1);
      #(HALF);
      chk("R1 first cycle lo mode0", q0, 1'b0);
      chk("R5 restart lo mode1", q1, 1'b1);
      @(posedge clk);
      #15;
      chk("R3 restart hi mode0", q0, 1'b1);
      #(HALF);
      chk("R4 restart lo mode0", q0, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule